// File: doc/BRIEF.md
# Programmable Synchronous Memory Sequencer

This block turns one internal burst request into the cycle-by-cycle pin activity of a synchronous external memory port. A request names the direction, a start address, a word count and, for writes, the data words with their byte enables. The sequencer issues one command per clock on consecutive cycles with an incrementing address. It drives write data a programmable number of cycles after each write command, and it captures read data a programmable number of cycles after each read command.

Two configuration bits let the same sequencer serve a pipelined burst SRAM or a synchronous FIFO behind glue logic. The strobe-function bit turns the shared strobe pin into either an address strobe that is followed by a deselect cycle, or a FIFO read enable that never deselects. The chip-enable extension bit decides whether chip enable drops right after the last command or stays asserted for as long as output enable does. All configuration is sampled when the request is accepted.

Top module: `syncmem_seq`

## Requirements
- R1: Out of reset and whenever no burst is in progress, `req_ready` is 1, the strobes `mem_ce_n`, `mem_ads_n`, `mem_oe_n` and `mem_we_n` are all 1, `mem_dq_oe` is 0, `mem_be_n` is all ones and `mem_addr` is 0.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 for the whole burst, and a request held valid during a burst is ignored. Call the cycle after acceptance tick 0. For N words and latency L (the write latency for writes, the read latency for reads), `done` is 1 in tick N+L only and `req_ready` returns to 1 in tick N+L+1.
- R3: Commands occupy ticks 0..N-1. In tick k, `mem_addr` is the start address plus k, modulo 2^AW. `mem_we_n` is 0 in exactly these ticks for a write and stays 1 for a read. The request field `req_len` encodes N-1.
- R4: For a read with latency RL, `mem_oe_n` is 0 in ticks 0..N-1+RL. Word k is sampled from `mem_dq_in` at the rising edge that ends tick k+RL. In the `done` cycle, word k appears at `rd_data[k*DW +: DW]`.
- R5: For a write with latency WL, `mem_dq_oe` is 1 in ticks WL..N-1+WL. In tick k+WL, `mem_dq_out` carries `req_wdata[k*DW +: DW]` and `mem_be_n` is the inverse of `req_be[k*BW +: BW]`. A read drives `mem_be_n` to all zeros in its command ticks.
- R6: With `cfg_ce_ext`=0, `mem_ce_n` is 0 in ticks 0..N-1 only.
- R7: With `cfg_ce_ext`=1, a read keeps `mem_ce_n` at 0 through tick N-1+RL, covering every output-enable tick. A write behaves as in R6.
- R8: With `cfg_fifo_mode`=0, `mem_ads_n` is 0 in every command tick and in one deselect tick right after the last chip-enable tick, during which `mem_ce_n` is 1.
- R9: With `cfg_fifo_mode`=1, `mem_ads_n` is 0 only in the command ticks of a read, and is never 0 while `mem_ce_n` is 1.
- R10: The `cfg_*` inputs are sampled at acceptance. Changing them during a burst has no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | AW | Start word address |
| req_len | input | LW | Number of words minus one |
| req_wdata | input | MAX_BURST*DW | Write words, word k at bits k*DW |
| req_be | input | MAX_BURST*BW | Byte enables, active high, word k at bits k*BW |
| cfg_rd_lat | input | 2 | Read latency in cycles |
| cfg_wr_lat | input | 2 | Write latency in cycles |
| cfg_ce_ext | input | 1 | Hold chip enable while output enable is active |
| cfg_fifo_mode | input | 1 | Strobe pin acts as FIFO read enable |
| done | output | 1 | One-cycle end-of-burst pulse |
| rd_data | output | MAX_BURST*DW | Captured read words |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_ads_n | output | 1 | Address strobe or FIFO read enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | AW | Memory address |
| mem_be_n | output | BW | Byte enables, active low |
| mem_dq_out | output | DW | Write data out |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | DW | Read data in |

## Verification
On every cycle, the assertions check the following relations: quiet pins while idle, write enable only under chip enable, no bus drive while output enable is low, write data following write enable at latencies 0 and 1, chip enable covering output enable in extension mode, the deselect on chip-enable release in SRAM mode, and no deselect in FIFO mode. Exact tick positions and address values need the bench's scenarios. So do the correct data word and byte lanes in each slot, the captured read words, and the `done` timing for every latency. The same holds for the proof that configuration changed mid-burst and a request held during a burst have no effect.

// File: rtl/syncmem_seq_pkg.sv
package syncmem_seq_pkg;

  typedef struct packed {
    logic [1:0] rd_lat;
    logic [1:0] wr_lat;
    logic       ce_ext;
    logic       fifo_mode;
  } seq_cfg_t;

  // Tick in which the burst finishes (done tick).
  function automatic int f_last_tick(int nwords, logic is_wr, seq_cfg_t c);
    return nwords + int'(is_wr ? c.wr_lat : c.rd_lat);
  endfunction

  // Last tick with chip enable asserted.
  function automatic int f_ce_last(int nwords, logic is_wr, logic ce_ext, logic [1:0] rd_lat);
    return nwords - 1 + ((ce_ext && !is_wr) ? int'(rd_lat) : 0);
  endfunction

  // Last tick with output enable asserted on a read.
  function automatic int f_oe_last(int nwords, logic [1:0] rd_lat);
    return nwords - 1 + int'(rd_lat);
  endfunction

  // Data word index served in a tick for a given latency.
  function automatic int f_word_idx(int tick, logic [1:0] lat);
    return tick - int'(lat);
  endfunction

  function automatic logic f_in_window(int idx, int nwords);
    return (idx >= 0) && (idx < nwords);
  endfunction

endpackage

// File: rtl/syncmem_seq_ctrl.sv
module syncmem_seq_ctrl
  import syncmem_seq_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int BW        = 2,
  parameter int MAX_BURST = 4,
  parameter int LW        = 2,
  parameter int TW        = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [AW-1:0]           req_addr,
  input  logic [LW-1:0]           req_len,
  input  logic [MAX_BURST*DW-1:0] req_wdata,
  input  logic [MAX_BURST*BW-1:0] req_be,
  input  seq_cfg_t                cfg_in,
  output logic                    req_ready,
  output logic                    busy,
  output logic [TW-1:0]           tick,
  output logic [TW-1:0]           nwords,
  output logic                    is_wr,
  output logic [AW-1:0]           base_addr,
  output logic [MAX_BURST*DW-1:0] wdata_q,
  output logic [MAX_BURST*BW-1:0] be_q,
  output seq_cfg_t                cfg_q,
  output logic                    done
);

  logic          busy_q;
  logic [TW-1:0] tick_q;
  logic [TW-1:0] nwords_q;
  logic          is_wr_q;
  logic [AW-1:0] base_q;
  logic [TW-1:0] last_tick;
  logic          accept;
  logic          at_last;

  assign accept    = req_valid && !busy_q;
  assign last_tick = TW'(f_last_tick(int'(nwords_q), is_wr_q, cfg_q));
  assign at_last   = (tick_q == last_tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      tick_q   <= '0;
      nwords_q <= '0;
      is_wr_q  <= 1'b0;
      base_q   <= '0;
      wdata_q  <= '0;
      be_q     <= '0;
      cfg_q    <= '0;
    end else if (accept) begin
      busy_q   <= 1'b1;
      tick_q   <= '0;
      nwords_q <= TW'(req_len) + TW'(1);
      is_wr_q  <= req_write;
      base_q   <= req_addr;
      wdata_q  <= req_wdata;
      be_q     <= req_be;
      cfg_q    <= cfg_in;
    end else if (busy_q) begin
      if (at_last) begin
        busy_q <= 1'b0;
        tick_q <= '0;
      end else begin
        tick_q <= tick_q + TW'(1);
      end
    end
  end

  assign req_ready = !busy_q;
  assign busy      = busy_q;
  assign tick      = tick_q;
  assign nwords    = nwords_q;
  assign is_wr     = is_wr_q;
  assign base_addr = base_q;
  assign done      = busy_q && at_last;

endmodule

// File: rtl/syncmem_seq_strobe.sv
module syncmem_seq_strobe
  import syncmem_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 2,
  parameter int TW = 4
) (
  input  logic          busy,
  input  logic [TW-1:0] tick,
  input  logic [TW-1:0] nwords,
  input  logic          is_wr,
  input  logic [1:0]    rd_lat,
  input  logic          ce_ext,
  input  logic          fifo_mode,
  input  logic [AW-1:0] base_addr,
  output logic          ce_n,
  output logic          ads_n,
  output logic          oe_n,
  output logic          we_n,
  output logic [AW-1:0] addr,
  output logic [BW-1:0] rd_be_n
);

  int   t_i;
  int   n_i;
  int   ce_last;
  int   oe_last;
  logic in_cmd;
  logic ce_on;
  logic oe_on;
  logic desel;
  logic ads_on;

  assign t_i     = int'(tick);
  assign n_i     = int'(nwords);
  assign ce_last = f_ce_last(n_i, is_wr, ce_ext, rd_lat);
  assign oe_last = f_oe_last(n_i, rd_lat);

  assign in_cmd = busy && (t_i < n_i);
  assign ce_on  = busy && (t_i <= ce_last);
  assign oe_on  = busy && !is_wr && (t_i <= oe_last);
  assign desel  = busy && !fifo_mode && (t_i == ce_last + 1);
  assign ads_on = fifo_mode ? (in_cmd && !is_wr) : (in_cmd || desel);

  assign ce_n    = !ce_on;
  assign oe_n    = !oe_on;
  assign we_n    = !(in_cmd && is_wr);
  assign ads_n   = !ads_on;
  assign addr    = in_cmd ? (base_addr + AW'(tick)) : '0;
  assign rd_be_n = (in_cmd && !is_wr) ? '0 : '1;

endmodule

// File: rtl/syncmem_seq_wdata.sv
module syncmem_seq_wdata
  import syncmem_seq_pkg::*;
#(
  parameter int DW        = 16,
  parameter int BW        = 2,
  parameter int MAX_BURST = 4,
  parameter int TW        = 4
) (
  input  logic                    busy,
  input  logic [TW-1:0]           tick,
  input  logic [TW-1:0]           nwords,
  input  logic                    is_wr,
  input  logic [1:0]              wr_lat,
  input  logic [MAX_BURST*DW-1:0] wdata_q,
  input  logic [MAX_BURST*BW-1:0] be_q,
  output logic [DW-1:0]           dq_out,
  output logic                    dq_oe,
  output logic [BW-1:0]           wr_be_n
);

  int   k;
  logic phase;

  assign k     = f_word_idx(int'(tick), wr_lat);
  assign phase = busy && is_wr && f_in_window(k, int'(nwords));
  assign dq_oe = phase;

  always_comb begin
    dq_out  = '0;
    wr_be_n = '1;
    if (phase) begin
      for (int i = 0; i < MAX_BURST; i++) begin
        if (k == i) begin
          dq_out  = wdata_q[i*DW +: DW];
          wr_be_n = ~be_q[i*BW +: BW];
        end
      end
    end
  end

endmodule

// File: rtl/syncmem_seq_rcap.sv
module syncmem_seq_rcap
  import syncmem_seq_pkg::*;
#(
  parameter int DW        = 16,
  parameter int MAX_BURST = 4,
  parameter int TW        = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    busy,
  input  logic [TW-1:0]           tick,
  input  logic [TW-1:0]           nwords,
  input  logic                    is_wr,
  input  logic [1:0]              rd_lat,
  input  logic [DW-1:0]           dq_in,
  output logic [MAX_BURST*DW-1:0] rd_data
);

  int   k;
  logic cap_en;

  assign k      = f_word_idx(int'(tick), rd_lat);
  assign cap_en = busy && !is_wr && f_in_window(k, int'(nwords));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (cap_en) begin
      for (int i = 0; i < MAX_BURST; i++) begin
        if (k == i) rd_data[i*DW +: DW] <= dq_in;
      end
    end
  end

endmodule

// File: rtl/syncmem_seq.sv
module syncmem_seq
  import syncmem_seq_pkg::*;
#(
  parameter  int AW        = 16,
  parameter  int DW        = 16,
  parameter  int MAX_BURST = 4,
  localparam int BW        = DW / 8,
  localparam int LW        = $clog2(MAX_BURST)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [AW-1:0]           req_addr,
  input  logic [LW-1:0]           req_len,
  input  logic [MAX_BURST*DW-1:0] req_wdata,
  input  logic [MAX_BURST*BW-1:0] req_be,
  input  logic [1:0]              cfg_rd_lat,
  input  logic [1:0]              cfg_wr_lat,
  input  logic                    cfg_ce_ext,
  input  logic                    cfg_fifo_mode,
  output logic                    done,
  output logic [MAX_BURST*DW-1:0] rd_data,
  output logic                    mem_ce_n,
  output logic                    mem_ads_n,
  output logic                    mem_oe_n,
  output logic                    mem_we_n,
  output logic [AW-1:0]           mem_addr,
  output logic [BW-1:0]           mem_be_n,
  output logic [DW-1:0]           mem_dq_out,
  output logic                    mem_dq_oe,
  input  logic [DW-1:0]           mem_dq_in
);

  localparam int TW = $clog2(MAX_BURST + 4) + 1;

  seq_cfg_t                cfg_in;
  seq_cfg_t                st_cfg;
  logic                    st_busy;
  logic [TW-1:0]           st_tick;
  logic [TW-1:0]           st_nwords;
  logic                    st_write;
  logic [AW-1:0]           st_base;
  logic [MAX_BURST*DW-1:0] st_wdata;
  logic [MAX_BURST*BW-1:0] st_be;
  logic [BW-1:0]           rd_be_n;
  logic [BW-1:0]           wr_be_n;

  // Named state for the bound checker.
  logic       st_fifo;
  logic       st_ce_ext;
  logic [1:0] st_wl;

  assign cfg_in.rd_lat    = cfg_rd_lat;
  assign cfg_in.wr_lat    = cfg_wr_lat;
  assign cfg_in.ce_ext    = cfg_ce_ext;
  assign cfg_in.fifo_mode = cfg_fifo_mode;

  assign st_fifo   = st_cfg.fifo_mode;
  assign st_ce_ext = st_cfg.ce_ext;
  assign st_wl     = st_cfg.wr_lat;

  syncmem_seq_ctrl #(
    .AW(AW), .DW(DW), .BW(BW), .MAX_BURST(MAX_BURST), .LW(LW), .TW(TW)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .req_wdata (req_wdata),
    .req_be    (req_be),
    .cfg_in    (cfg_in),
    .req_ready (req_ready),
    .busy      (st_busy),
    .tick      (st_tick),
    .nwords    (st_nwords),
    .is_wr     (st_write),
    .base_addr (st_base),
    .wdata_q   (st_wdata),
    .be_q      (st_be),
    .cfg_q     (st_cfg),
    .done      (done)
  );

  syncmem_seq_strobe #(.AW(AW), .BW(BW), .TW(TW)) u_strobe (
    .busy      (st_busy),
    .tick      (st_tick),
    .nwords    (st_nwords),
    .is_wr     (st_write),
    .rd_lat    (st_cfg.rd_lat),
    .ce_ext    (st_cfg.ce_ext),
    .fifo_mode (st_cfg.fifo_mode),
    .base_addr (st_base),
    .ce_n      (mem_ce_n),
    .ads_n     (mem_ads_n),
    .oe_n      (mem_oe_n),
    .we_n      (mem_we_n),
    .addr      (mem_addr),
    .rd_be_n   (rd_be_n)
  );

  syncmem_seq_wdata #(.DW(DW), .BW(BW), .MAX_BURST(MAX_BURST), .TW(TW)) u_wdata (
    .busy    (st_busy),
    .tick    (st_tick),
    .nwords  (st_nwords),
    .is_wr   (st_write),
    .wr_lat  (st_cfg.wr_lat),
    .wdata_q (st_wdata),
    .be_q    (st_be),
    .dq_out  (mem_dq_out),
    .dq_oe   (mem_dq_oe),
    .wr_be_n (wr_be_n)
  );

  syncmem_seq_rcap #(.DW(DW), .MAX_BURST(MAX_BURST), .TW(TW)) u_rcap (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (st_busy),
    .tick    (st_tick),
    .nwords  (st_nwords),
    .is_wr   (st_write),
    .rd_lat  (st_cfg.rd_lat),
    .dq_in   (mem_dq_in),
    .rd_data (rd_data)
  );

  // Active-low merge: a lane is enabled if either phase enables it.
  assign mem_be_n = rd_be_n & wr_be_n;

endmodule

// File: rtl/syncmem_seq_chk.sv
module syncmem_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       done,
  input logic       mem_ce_n,
  input logic       mem_ads_n,
  input logic       mem_oe_n,
  input logic       mem_we_n,
  input logic       mem_dq_oe,
  input logic       st_busy,
  input logic       st_fifo,
  input logic       st_ce_ext,
  input logic [1:0] st_wl
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !st_busy |-> (mem_ce_n && mem_ads_n && mem_oe_n && mem_we_n && !mem_dq_oe));

  a_r2_accept_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));

  a_r3_we_under_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);

  a_r4_no_bus_fight: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);

  a_r5_wl0_data: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && st_wl == 2'd0) |-> mem_dq_oe);

  a_r5_wl1_data: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && st_wl == 2'd1) |=> mem_dq_oe);

  a_r6_ce_only_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (st_busy && !st_ce_ext && !mem_ce_n) |-> (!mem_we_n || !mem_ads_n));

  a_r7_ce_covers_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (st_busy && st_ce_ext && !mem_oe_n) |-> !mem_ce_n);

  a_r8_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (st_busy && !st_fifo && $rose(mem_ce_n)) |-> !mem_ads_n);

  a_r9_fifo_no_desel: assert property (@(posedge clk) disable iff (!rst_n)
    (st_busy && st_fifo) |-> !(!mem_ads_n && mem_ce_n));

endmodule

bind syncmem_seq syncmem_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .done      (done),
  .mem_ce_n  (mem_ce_n),
  .mem_ads_n (mem_ads_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_dq_oe (mem_dq_oe),
  .st_busy   (st_busy),
  .st_fifo   (st_fifo),
  .st_ce_ext (st_ce_ext),
  .st_wl     (st_wl)
);

// File: tb/syncmem_seq_tb.sv
module syncmem_seq_tb_top;

  localparam int AW = 16;
  localparam int DW = 16;
  localparam int MB = 4;
  localparam int BW = DW / 8;
  localparam int LW = $clog2(MB);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [AW-1:0]     req_addr = '0;
  logic [LW-1:0]     req_len = '0;
  logic [MB*DW-1:0]  req_wdata = '0;
  logic [MB*BW-1:0]  req_be = '0;
  logic [1:0]        cfg_rd_lat = '0;
  logic [1:0]        cfg_wr_lat = '0;
  logic              cfg_ce_ext = 1'b0;
  logic              cfg_fifo_mode = 1'b0;
  logic              done;
  logic [MB*DW-1:0]  rd_data;
  logic              mem_ce_n, mem_ads_n, mem_oe_n, mem_we_n;
  logic [AW-1:0]     mem_addr;
  logic [BW-1:0]     mem_be_n;
  logic [DW-1:0]     mem_dq_out;
  logic              mem_dq_oe;
  logic [DW-1:0]     mem_dq_in = '0;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  syncmem_seq #(.AW(AW), .DW(DW), .MAX_BURST(MB)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .req_wdata(req_wdata), .req_be(req_be), .cfg_rd_lat(cfg_rd_lat),
    .cfg_wr_lat(cfg_wr_lat), .cfg_ce_ext(cfg_ce_ext), .cfg_fifo_mode(cfg_fifo_mode),
    .done(done), .rd_data(rd_data), .mem_ce_n(mem_ce_n), .mem_ads_n(mem_ads_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
    .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected pin values per tick, restated from the requirements.
  function automatic bit e_ce_n(int t, int n, bit wr, int rl, bit ext);
    int ce_end = n - 1 + ((ext && !wr) ? rl : 0);
    return !(t <= ce_end);
  endfunction

  function automatic bit e_ads_n(int t, int n, bit wr, int rl, bit ext, bit fifo);
    int ce_end = n - 1 + ((ext && !wr) ? rl : 0);
    if (fifo) return !(!wr && t < n);
    return !(t < n || t == ce_end + 1);
  endfunction

  function automatic bit e_oe_n(int t, int n, bit wr, int rl);
    return !(!wr && t <= n - 1 + rl);
  endfunction

  function automatic logic [DW-1:0] rd_word(logic [AW-1:0] a, int k, logic [DW-1:0] salt);
    return DW'(a + AW'(k)) ^ salt ^ 16'h5A00;
  endfunction

  task automatic check_idle(input string tag);
    chk(req_ready == 1'b1, {tag, " R1 ready"}, 64'(req_ready), 1);
    chk({mem_ce_n, mem_ads_n, mem_oe_n, mem_we_n} == 4'hF, {tag, " R1 strobes"},
        64'({mem_ce_n, mem_ads_n, mem_oe_n, mem_we_n}), 64'hF);
    chk(mem_dq_oe == 1'b0, {tag, " R1 dq_oe"}, 64'(mem_dq_oe), 0);
    chk(mem_be_n == '1 && mem_addr == '0, {tag, " R1 be/addr"},
        64'({mem_be_n, mem_addr}), 64'({{BW{1'b1}}, {AW{1'b0}}}));
    chk(done == 1'b0, {tag, " R2 no done when idle"}, 64'(done), 0);
  endtask

  task automatic run_txn(input bit wr, input logic [AW-1:0] a, input int n, input int rl,
                         input int wl, input bit ext, input bit fifo, input bit hold);
    logic [DW-1:0] wd [MB];
    logic [BW-1:0] be [MB];
    logic [DW-1:0] salt;
    int last;
    salt = DW'($urandom);
    for (int k = 0; k < MB; k++) begin
      wd[k] = DW'($urandom);
      be[k] = BW'($urandom);
      req_wdata[k*DW +: DW] = wd[k];
      req_be[k*BW +: BW]    = be[k];
    end
    @(negedge clk);
    chk(req_ready == 1'b1, "R2 ready before request", 64'(req_ready), 1);
    req_write = wr; req_addr = a; req_len = LW'(n - 1);
    cfg_rd_lat = 2'(rl); cfg_wr_lat = 2'(wl); cfg_ce_ext = ext; cfg_fifo_mode = fifo;
    req_valid = 1'b1;
    @(posedge clk);
    last = n + (wr ? wl : rl);
    for (int t = 0; t <= last; t++) begin
      @(negedge clk);
      if (t == 0) begin
        if (!hold) req_valid = 1'b0;
        // R10: scramble configuration after acceptance
        cfg_rd_lat = 2'(rl + 1); cfg_wr_lat = 2'(wl + 2);
        cfg_ce_ext = !ext; cfg_fifo_mode = !fifo;
      end
      chk(req_ready == 1'b0, "R2 ready low in burst", 64'(req_ready), 0);
      chk(mem_ce_n == e_ce_n(t, n, wr, rl, ext), ext ? "R7 ce_n" : "R6 ce_n",
          64'(mem_ce_n), 64'(e_ce_n(t, n, wr, rl, ext)));
      chk(mem_ads_n == e_ads_n(t, n, wr, rl, ext, fifo), fifo ? "R9 ads_n" : "R8 ads_n",
          64'(mem_ads_n), 64'(e_ads_n(t, n, wr, rl, ext, fifo)));
      chk(mem_oe_n == e_oe_n(t, n, wr, rl), "R4 oe_n", 64'(mem_oe_n), 64'(e_oe_n(t, n, wr, rl)));
      chk(mem_we_n == !(wr && t < n), "R3 we_n", 64'(mem_we_n), 64'(!(wr && t < n)));
      chk(mem_addr == ((t < n) ? a + AW'(t) : '0), "R3 addr", 64'(mem_addr),
          64'((t < n) ? a + AW'(t) : '0));
      if (wr && t >= wl && t < n + wl) begin
        chk(mem_dq_oe == 1'b1, "R5 dq_oe on", 64'(mem_dq_oe), 1);
        chk(mem_dq_out == wd[t - wl], "R5 dq_out", 64'(mem_dq_out), 64'(wd[t - wl]));
        chk(mem_be_n == ~be[t - wl], "R5 be_n write", 64'(mem_be_n), 64'(~be[t - wl]));
      end else begin
        chk(mem_dq_oe == 1'b0, "R5 dq_oe off", 64'(mem_dq_oe), 0);
        chk(mem_be_n == ((!wr && t < n) ? '0 : '1), "R5 be_n read/idle", 64'(mem_be_n),
            64'((!wr && t < n) ? {BW{1'b0}} : {BW{1'b1}}));
      end
      chk(done == (t == last), "R2 done timing", 64'(done), 64'(t == last));
      if (!wr && t == last) begin
        for (int k = 0; k < n; k++)
          chk(rd_data[k*DW +: DW] == rd_word(a, k, salt), "R4 read word",
              64'(rd_data[k*DW +: DW]), 64'(rd_word(a, k, salt)));
      end
      // memory model: word (t-rl) is presented for the edge ending tick t
      if (!wr && t - rl >= 0 && t - rl < n) mem_dq_in = rd_word(a, t - rl, salt);
      else mem_dq_in = 16'hDEAD;
      if (t == last) req_valid = 1'b0;
    end
    @(negedge clk);
    check_idle("after burst");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    check_idle("reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("post reset");
    // directed: every read and write latency, both modes
    for (int l = 0; l < 4; l++) begin
      run_txn(1'b0, 16'h0100, 4, l, 0, 1'b0, 1'b0, 1'b0);
      run_txn(1'b1, 16'h0200, 4, 0, l, 1'b0, 1'b0, 1'b0);
      run_txn(1'b0, 16'h0300, 3, l, 0, 1'b1, 1'b0, 1'b0);
      run_txn(1'b0, 16'h0400, 2, l, 0, 1'b1, 1'b1, 1'b0);
      run_txn(1'b1, 16'h0500, 3, 0, l, 1'b1, 1'b1, 1'b0);
    end
    // corners: single word, address wrap, request held during a burst
    run_txn(1'b0, 16'h0010, 1, 0, 0, 1'b0, 1'b0, 1'b0);
    run_txn(1'b1, 16'h0020, 1, 0, 3, 1'b1, 1'b0, 1'b1);
    run_txn(1'b0, 16'hFFFE, 4, 2, 0, 1'b0, 1'b1, 1'b0);
    run_txn(1'b1, 16'hFFFF, 4, 0, 1, 1'b0, 1'b0, 1'b1);
    // constrained random
    for (int i = 0; i < 200; i++) begin
      run_txn(1'($urandom), AW'($urandom), 1 + int'($urandom % MB), int'($urandom % 4),
              int'($urandom % 4), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule